// File: doc/BRIEF.md
# Glitch-Safe Pin Mode Sequencer

This block moves one or more pins of a general-purpose port from one pad mode to another without letting the pad pass through a harmful intermediate state. A pad mode is a 3-bit code held in three configuration planes, one register per bit. Each plane can only be changed by its own register write. The sequencer is told the current and the requested mode. It then issues one masked single-plane write per clock cycle to the port's register interface, so that the planes change one at a time. The order of those writes depends on the kind of transition.

By default the most significant plane is written first. When a pin leaves a plain or weak-pull input for an open-drain or driving output, the least significant plane is written first instead. This keeps the pad from driving an alternate-function level while the other planes are still being changed. A separate bring-up mode takes a pin from its reset state (floating input, data register 0) to open-drain alternate function. It goes through a pull-up input and a floating input on the way, so a shared open-drain bus line is never pulled or driven low.

Mode codes written {plane2, plane1, plane0}: 000 analog, 001 and 010 floating input, 011 weak-pull input (up when the data register holds 1, down when it holds 0), 100 open-drain output, 101 push-pull output, 110 open-drain alternate function, 111 push-pull alternate function.

Top module: `pin_mode_sequencer`

## Requirements
- R1: After reset, busy, done and the write strobe are all low.
- R2: A normal transition issues exactly three writes on consecutive cycles, even for planes whose value does not change. In default order the writes go to plane2, plane1, then plane0. Each write carries the target's bit for that plane. Default addresses are plane0 = 0, plane1 = 1, plane2 = 2, data register = 3.
- R3: From weak-pull input (011) to 100, 101 or 110, the order is reversed: plane0, plane1, then plane2. A target of 111 from 011 keeps the default order.
- R4: From floating input (001 or 010) to 100 or 110, the order is reversed. Other targets from these modes, such as 101, keep the default order.
- R5: A start with bring-up selected ignores the current and target modes and issues four writes: data = 1, plane1 = 1, plane0 = 0, plane2 = 1.
- R6: Starting from reset state 001 with data 0, no bring-up step leaves the pin in analog, in pull-down input, or in an output mode with data 0. The pin ends in 110 with data 1.
- R7: Busy rises in the cycle after start is sampled and stays high until the cycle after the last write. Done is a one-cycle pulse in that final busy cycle, and no write occurs while done is high.
- R8: A normal start with target equal to current mode issues no write, keeps busy low, and pulses done in the cycle after start.
- R9: A start sampled while busy is ignored: the running sequence finishes unchanged and no further write follows.
- R10: Every write drives all data bits with the written value and carries the pin mask captured at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a mode change (sampled when idle) |
| cur_mode_i | input | 3 | Present pad mode code |
| tgt_mode_i | input | 3 | Requested pad mode code |
| bringup_i | input | 1 | Select the open-drain bus bring-up path |
| pin_mask_i | input | PIN_W | Pins affected by the change |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | ADDR_W | Register address of the write |
| wr_data_o | output | PIN_W | Write data, the plane value on every bit |
| wr_mask_o | output | PIN_W | Write mask, only set bits are changed |

## Verification
The assertions assume that start is a single-cycle pulse, apart from deliberate pulses during busy. They also assume that the mode inputs and bring-up select are stable in the cycle where start is sampled, and that bring-up is requested only for a pin still in reset state. The bench drives every input on the falling clock edge and pulses start for exactly one cycle. It requests bring-up only from the reset state that it models. It applies every issued write to its own model of the pad's planes and data register, so the intermediate states can be judged.

// File: rtl/pinseq_pkg.sv
package pinseq_pkg;

    // Register selected by one sequencer step
    typedef enum logic [1:0] {
        SEL_CFG0 = 2'd0,
        SEL_CFG1 = 2'd1,
        SEL_CFG2 = 2'd2,
        SEL_DATA = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_WRITE  = 2'd1,
        PH_FINISH = 2'd2
    } phase_e;

    localparam int MODE_W        = 3;
    localparam int STEP_W        = 2;
    localparam int NORMAL_STEPS  = 3;
    localparam int BRINGUP_STEPS = 4;

    // Pad mode codes {plane2, plane1, plane0}
    localparam logic [MODE_W-1:0] MODE_ANALOG   = 3'b000;
    localparam logic [MODE_W-1:0] MODE_IN_FLT_A = 3'b001;
    localparam logic [MODE_W-1:0] MODE_IN_FLT_B = 3'b010;
    localparam logic [MODE_W-1:0] MODE_IN_PULL  = 3'b011;
    localparam logic [MODE_W-1:0] MODE_OUT_OD   = 3'b100;
    localparam logic [MODE_W-1:0] MODE_OUT_PP   = 3'b101;
    localparam logic [MODE_W-1:0] MODE_AF_OD    = 3'b110;
    localparam logic [MODE_W-1:0] MODE_AF_PP    = 3'b111;

endpackage

// File: rtl/pinseq_order_class.sv
module pinseq_order_class
    import pinseq_pkg::*;
(
    input  logic [MODE_W-1:0] cur_mode_i,
    input  logic [MODE_W-1:0] tgt_mode_i,
    output logic              reverse_o,
    output logic              same_o
);

    logic from_pull;
    logic from_float;
    logic to_pull_class;
    logic to_float_class;

    always_comb begin
        from_pull      = (cur_mode_i == MODE_IN_PULL);
        from_float     = (cur_mode_i == MODE_IN_FLT_A) || (cur_mode_i == MODE_IN_FLT_B);
        // Targets that need plane0 first when leaving a weak-pull input
        to_pull_class  = (tgt_mode_i == MODE_OUT_OD) || (tgt_mode_i == MODE_OUT_PP)
                       || (tgt_mode_i == MODE_AF_OD);
        // Targets that need plane0 first when leaving a floating input
        to_float_class = (tgt_mode_i == MODE_OUT_OD) || (tgt_mode_i == MODE_AF_OD);
        reverse_o      = (from_pull && to_pull_class) || (from_float && to_float_class);
        same_o         = (cur_mode_i == tgt_mode_i);
    end

endmodule

// File: rtl/pinseq_step_decode.sv
module pinseq_step_decode
    import pinseq_pkg::*;
(
    input  logic [STEP_W-1:0] step_i,
    input  logic              reverse_i,
    input  logic              bringup_i,
    input  logic [MODE_W-1:0] tgt_mode_i,
    output reg_sel_e          sel_o,
    output logic              bit_o
);

    logic [STEP_W-1:0] plane;

    always_comb begin
        plane = reverse_i ? step_i : (2'd2 - step_i);
        sel_o = SEL_CFG0;
        bit_o = 1'b0;
        if (bringup_i) begin
            // Pull-up first, then float, then hand over to open-drain
            case (step_i)
                2'd0:    begin sel_o = SEL_DATA; bit_o = 1'b1; end
                2'd1:    begin sel_o = SEL_CFG1; bit_o = 1'b1; end
                2'd2:    begin sel_o = SEL_CFG0; bit_o = 1'b0; end
                default: begin sel_o = SEL_CFG2; bit_o = 1'b1; end
            endcase
        end else begin
            case (plane)
                2'd0:    begin sel_o = SEL_CFG0; bit_o = tgt_mode_i[0]; end
                2'd1:    begin sel_o = SEL_CFG1; bit_o = tgt_mode_i[1]; end
                2'd2:    begin sel_o = SEL_CFG2; bit_o = tgt_mode_i[2]; end
                default: begin sel_o = SEL_CFG0; bit_o = 1'b0; end
            endcase
        end
    end

endmodule

// File: rtl/pin_mode_sequencer.sv
module pin_mode_sequencer
    import pinseq_pkg::*;
#(
    parameter int PIN_W     = 16,
    parameter int ADDR_W    = 4,
    parameter int ADDR_CFG0 = 0,
    parameter int ADDR_CFG1 = 1,
    parameter int ADDR_CFG2 = 2,
    parameter int ADDR_DATA = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MODE_W-1:0] cur_mode_i,
    input  logic [MODE_W-1:0] tgt_mode_i,
    input  logic              bringup_i,
    input  logic [PIN_W-1:0]  pin_mask_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [PIN_W-1:0]  wr_data_o,
    output logic [PIN_W-1:0]  wr_mask_o
);

    localparam logic [STEP_W-1:0] LAST_NORMAL  = STEP_W'(NORMAL_STEPS - 1);
    localparam logic [STEP_W-1:0] LAST_BRINGUP = STEP_W'(BRINGUP_STEPS - 1);

    typedef struct packed {
        phase_e              phase;
        logic [STEP_W-1:0]   step;
        logic                rev;
        logic                bring;
        logic [MODE_W-1:0]   tgt;
        logic [PIN_W-1:0]    mask;
        logic                wr_en;
        logic [ADDR_W-1:0]   addr;
        logic [PIN_W-1:0]    data;
        logic                done;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic              cls_reverse;
    logic              cls_same;
    logic              idle;
    logic [STEP_W-1:0] dec_step;
    logic              dec_rev;
    logic              dec_bring;
    logic [MODE_W-1:0] dec_tgt;
    reg_sel_e          dec_sel;
    logic              dec_bit;
    logic              at_last;

    pinseq_order_class u_class (
        .cur_mode_i (cur_mode_i),
        .tgt_mode_i (tgt_mode_i),
        .reverse_o  (cls_reverse),
        .same_o     (cls_same)
    );

    // The decoder looks one step ahead so that writes leave a register
    pinseq_step_decode u_decode (
        .step_i     (dec_step),
        .reverse_i  (dec_rev),
        .bringup_i  (dec_bring),
        .tgt_mode_i (dec_tgt),
        .sel_o      (dec_sel),
        .bit_o      (dec_bit)
    );

    function automatic logic [ADDR_W-1:0] sel_to_addr(input reg_sel_e sel);
        case (sel)
            SEL_CFG0: sel_to_addr = ADDR_W'(ADDR_CFG0);
            SEL_CFG1: sel_to_addr = ADDR_W'(ADDR_CFG1);
            SEL_CFG2: sel_to_addr = ADDR_W'(ADDR_CFG2);
            default:  sel_to_addr = ADDR_W'(ADDR_DATA);
        endcase
    endfunction

    always_comb begin
        idle      = (st_q.phase == PH_IDLE);
        dec_step  = idle ? '0 : st_q.step + 1'b1;
        dec_rev   = idle ? cls_reverse : st_q.rev;
        dec_bring = idle ? bringup_i : st_q.bring;
        dec_tgt   = idle ? tgt_mode_i : st_q.tgt;
        at_last   = (st_q.step == (st_q.bring ? LAST_BRINGUP : LAST_NORMAL));

        st_d       = st_q;
        st_d.wr_en = 1'b0;
        st_d.done  = 1'b0;

        case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    if (!bringup_i && cls_same) begin
                        st_d.done = 1'b1;
                    end else begin
                        st_d.phase = PH_WRITE;
                        st_d.step  = '0;
                        st_d.rev   = cls_reverse;
                        st_d.bring = bringup_i;
                        st_d.tgt   = tgt_mode_i;
                        st_d.mask  = pin_mask_i;
                        st_d.wr_en = 1'b1;
                        st_d.addr  = sel_to_addr(dec_sel);
                        st_d.data  = {PIN_W{dec_bit}};
                    end
                end
            end
            PH_WRITE: begin
                if (at_last) begin
                    st_d.phase = PH_FINISH;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.step  = dec_step;
                    st_d.wr_en = 1'b1;
                    st_d.addr  = sel_to_addr(dec_sel);
                    st_d.data  = {PIN_W{dec_bit}};
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o    = (st_q.phase != PH_IDLE);
    assign done_o    = st_q.done;
    assign wr_en_o   = st_q.wr_en;
    assign wr_addr_o = st_q.addr;
    assign wr_data_o = st_q.data;
    assign wr_mask_o = st_q.mask;

    AST_WRITE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> busy_o); // R7

    AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_DONE_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !wr_en_o); // R7

    AST_SAME_MODE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !bringup_i && (cur_mode_i == tgt_mode_i))
        |=> (done_o && !busy_o && !wr_en_o)); // R8

    AST_BUSY_KEEPS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> ($stable(st_q.tgt) && $stable(wr_mask_o))); // R9

    AST_BRINGUP_DATA_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && st_q.bring && (wr_addr_o == ADDR_W'(ADDR_DATA))) |-> (&wr_data_o)); // R6

    AST_BRINGUP_PULL_BEFORE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && st_q.bring && (wr_addr_o == ADDR_W'(ADDR_CFG0)))
        |-> ($past(wr_en_o) && ($past(wr_addr_o) == ADDR_W'(ADDR_CFG1)) && $past(wr_data_o[0]))); // R6

endmodule

// File: tb/pin_mode_sequencer_tb.sv
module pin_mode_sequencer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PIN_W      = 16;
    localparam int ADDR_W     = 4;
    localparam int WATCHDOG   = 5000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [2:0]        cur_mode_i = '0;
    logic [2:0]        tgt_mode_i = '0;
    logic              bringup_i = 1'b0;
    logic [PIN_W-1:0]  pin_mask_i = '0;
    logic              busy_o, done_o, wr_en_o;
    logic [ADDR_W-1:0] wr_addr_o;
    logic [PIN_W-1:0]  wr_data_o, wr_mask_o;

    int n_checks = 0;
    int n_fail   = 0;

    // Bench model of one pad: planes and data register
    logic [2:0] pad_mode;
    logic       pad_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_mode_sequencer #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .cur_mode_i(cur_mode_i), .tgt_mode_i(tgt_mode_i),
        .bringup_i(bringup_i), .pin_mask_i(pin_mask_i),
        .busy_o(busy_o), .done_o(done_o), .wr_en_o(wr_en_o),
        .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_mask_o(wr_mask_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit expect_reverse(input logic [2:0] cur, input logic [2:0] tgt);
        bit from_pull  = (cur == 3'b011);
        bit from_float = (cur == 3'b001) || (cur == 3'b010);
        return (from_pull && (tgt == 3'b100 || tgt == 3'b101 || tgt == 3'b110))
            || (from_float && (tgt == 3'b100 || tgt == 3'b110));
    endfunction

    function automatic bit pad_is_low(input logic [2:0] m, input logic d);
        return (m == 3'b000) || (m == 3'b011 && !d) || (m[2:1] == 2'b10 && !d);
    endfunction

    // Runs one request and checks every cycle of it against the requirements
    task automatic run_seq(input logic [2:0] cur, input logic [2:0] tgt, input bit bring,
                           input logic [PIN_W-1:0] mask, input bit inject, input string req);
        int n;
        logic [3:0]  exp_addr [4];
        logic        exp_bit  [4];
        bit rev = expect_reverse(cur, tgt);
        if (bring) begin
            n = 4;
            exp_addr[0] = 4'd3; exp_bit[0] = 1'b1;
            exp_addr[1] = 4'd1; exp_bit[1] = 1'b1;
            exp_addr[2] = 4'd0; exp_bit[2] = 1'b0;
            exp_addr[3] = 4'd2; exp_bit[3] = 1'b1;
            pad_mode = 3'b001; pad_data = 1'b0;
        end else if (cur == tgt) begin
            n = 0;
        end else begin
            n = 3;
            for (int i = 0; i < 3; i++) begin
                int p = rev ? i : 2 - i;
                exp_addr[i] = 4'(p);
                exp_bit[i]  = tgt[p];
            end
        end
        @(negedge clk);
        start_i = 1'b1; cur_mode_i = cur; tgt_mode_i = tgt;
        bringup_i = bring; pin_mask_i = mask;
        @(negedge clk);
        for (int k = 0; k <= n + 1; k++) begin
            if (k < n) begin
                chk(wr_en_o == 1'b1, req, $sformatf("write strobe step %0d", k), 32'(wr_en_o), 1);
                chk(wr_addr_o == exp_addr[k], req, $sformatf("address step %0d", k),
                    32'(wr_addr_o), 32'(exp_addr[k]));
                chk(wr_data_o == {PIN_W{exp_bit[k]}}, "R10", $sformatf("data step %0d", k),
                    32'(wr_data_o), 32'({PIN_W{exp_bit[k]}}));
                chk(wr_mask_o == mask, "R10", "write mask", 32'(wr_mask_o), 32'(mask));
                chk(busy_o && !done_o, "R7", "busy without done during writes",
                    {30'd0, busy_o, done_o}, 32'h2);
                if (bring) begin
                    case (wr_addr_o)
                        4'd0: pad_mode[0] = wr_data_o[0];
                        4'd1: pad_mode[1] = wr_data_o[0];
                        4'd2: pad_mode[2] = wr_data_o[0];
                        default: pad_data = wr_data_o[0];
                    endcase
                    chk(!pad_is_low(pad_mode, pad_data), "R6", $sformatf("pad state after step %0d", k),
                        {28'd0, pad_mode, pad_data}, 0);
                end
            end else if (k == n) begin
                chk(!wr_en_o, "R7", "no write with done", 32'(wr_en_o), 0);
                chk(done_o, (n == 0) ? "R8" : "R7", "done pulse", 32'(done_o), 1);
                chk(busy_o == (n > 0), (n == 0) ? "R8" : "R7", "busy in done cycle",
                    32'(busy_o), 32'(n > 0));
            end else begin
                chk(!busy_o && !done_o && !wr_en_o, "R7", "idle after done",
                    {29'd0, busy_o, done_o, wr_en_o}, 0);
            end
            if (inject && k == 1) begin
                start_i = 1'b1; tgt_mode_i = ~tgt; bringup_i = 1'b0;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        if (bring)
            chk(pad_mode == 3'b110 && pad_data, "R6", "final bring-up state",
                {28'd0, pad_mode, pad_data}, 32'hD);
        if (inject) begin
            for (int j = 0; j < 3; j++) begin
                chk(!wr_en_o && !busy_o, "R9", "no write after ignored start",
                    {30'd0, wr_en_o, busy_o}, 0);
                @(negedge clk);
            end
        end
    endtask

    task automatic test_reset();
        chk(!busy_o && !done_o && !wr_en_o, "R1", "outputs after reset",
            {29'd0, busy_o, done_o, wr_en_o}, 0);
    endtask

    task automatic test_default_order();
        run_seq(3'b111, 3'b000, 1'b0, 16'hFFFF, 1'b0, "R2");
        run_seq(3'b000, 3'b101, 1'b0, 16'h00F0, 1'b0, "R2");
        run_seq(3'b011, 3'b111, 1'b0, 16'h0001, 1'b0, "R3");
    endtask

    task automatic test_pull_reverse();
        run_seq(3'b011, 3'b100, 1'b0, 16'h8000, 1'b0, "R3");
        run_seq(3'b011, 3'b101, 1'b0, 16'h0300, 1'b0, "R3");
        run_seq(3'b011, 3'b110, 1'b0, 16'hA5A5, 1'b0, "R3");
    endtask

    task automatic test_float_reverse();
        run_seq(3'b001, 3'b100, 1'b0, 16'h0002, 1'b0, "R4");
        run_seq(3'b010, 3'b110, 1'b0, 16'h1000, 1'b0, "R4");
        run_seq(3'b001, 3'b101, 1'b0, 16'h0044, 1'b0, "R4");
    endtask

    task automatic test_bringup();
        run_seq(3'b001, 3'b001, 1'b1, 16'h0C00, 1'b0, "R5");
        run_seq(3'b111, 3'b000, 1'b1, 16'h0003, 1'b0, "R5");
    endtask

    task automatic test_same_mode();
        run_seq(3'b101, 3'b101, 1'b0, 16'h0F0F, 1'b0, "R8");
    endtask

    task automatic test_ignore_busy_start();
        run_seq(3'b110, 3'b001, 1'b0, 16'h0080, 1'b1, "R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_default_order();
        test_pull_reverse();
        test_float_reverse();
        test_bringup();
        test_same_mode();
        test_ignore_busy_start();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule